// File: doc/BRIEF.md
# Adaptive Gain-Table Entry Updater (Normalised LMS)

This block keeps a complex gain table for a memoryless amplifier linearizer up to date while traffic flows. For each qualifying sample, the caller presents three things: the input sample x, the table index that sample was corrected with, and a feedback sample y. The feedback has already been time-aligned and normalised to unit gain. The block forms the error e = y − x and the product e·conj(x). It scales that product by a per-bin reciprocal of |x|² and by a programmable step size. It then rewrites the one addressed entry with the corrected, saturated gain.

The table sits inside the block. It has one write port, which a host loader and the adaptation engine share, and the host always wins. A separate registered lookup port serves the predistortion datapath. A step-size control sets how fast the table converges. An enable input gates adaptation. A wrapping counter records requests that arrive while an update is still in progress.

Top module: `lms_lut_updater`

## Requirements
- R1: After reset every entry holds unity gain: real part 16384 (the gain format is signed 16-bit with 14 fraction bits) and imaginary part 0. `busy` is low and `drop_count` is 0.
- R2: An accepted request for index k rewrites entry k as G − ((p·R(k)) >>> (18 + mu)), separately for the real and imaginary parts. Here:
  - e = y − x.
  - p = e·conj(x), so p_re = e_re·x_re + e_im·x_im and p_im = e_im·x_re − e_re·x_im.
  - R(k) = floor(65536 / (2k+1)²).
- R3: An accepted update changes no entry other than entry k.
- R4: With no host write in progress, `busy` is high for exactly the 4 cycles after the accepting clock edge. The new value is readable on the lookup port from then on.
- R5: A request with a nonzero index that arrives with `adapt_en` high while `busy` is high is discarded. It leaves the table unchanged and increments the 8-bit wrapping `drop_count` by one.
- R6: A request with index 0 is ignored. It starts no update and is not counted.
- R7: While `adapt_en` is low, requests are ignored and not counted. Clearing `adapt_en` during an update lets that update complete.
- R8: A host write takes effect at the clock edge where `host_we` is high. A pending adaptation write waits for as long as `host_we` stays high.
- R9: A host write to the entry being updated, made while `busy` is high, cancels that adaptation write. The host value remains in the table.
- R10: Updated parts saturate to the range −32768 to 32767.
- R11: The step shift `mu_shift` (0 to 15) is sampled at the accepting edge. Later changes do not affect the update already in flight.
- R12: The lookup port returns the entry at `lk_idx` one clock after the index is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adapt_en | input | 1 | Adaptation enable |
| mu_shift | input | 4 | Step size expressed as an extra right shift |
| req_valid | input | 1 | Update request strobe |
| req_idx | input | 6 | Table index that the sample used |
| x_re | input | 16 | Input sample, real part |
| x_im | input | 16 | Input sample, imaginary part |
| y_re | input | 16 | Aligned feedback, real part |
| y_im | input | 16 | Aligned feedback, imaginary part |
| host_we | input | 1 | Host table write strobe |
| host_idx | input | 6 | Host write index |
| host_re | input | 16 | Host gain, real part |
| host_im | input | 16 | Host gain, imaginary part |
| lk_idx | input | 6 | Lookup index |
| lk_re | output | 16 | Looked-up gain, real part |
| lk_im | output | 16 | Looked-up gain, imaginary part |
| busy | output | 1 | Read-modify-write in progress |
| drop_count | output | 8 | Count of discarded requests, wrapping |

## Verification
The bench checks the entries on either side of the updated one. A design that writes a wrong or stale address corrupts its neighbours, and those checks catch it.

It holds the host port busy during the write phase. A design without the stall would lose one of the two writes.

It overwrites the in-flight entry from the host mid-update. A design without cancellation would put back a value computed from the old gain.

It also covers the following:
- Rail saturation in both directions: a missing clamp shows up as a wrapped sign.
- A request arriving during an update: a design that queued it would change the second entry.
- An index-zero request.
- Disabled requests.
- A step-size change right after acceptance: a design that read `mu_shift` late would produce a different gain.

// File: rtl/lms_pkg.sv
package lms_pkg;

  localparam int SW = 16;            // sample and gain width
  localparam int EW = SW + 1;        // error width
  localparam int PW = EW + SW + 1;   // e*conj(x) component width
  localparam int RW = 16;            // reciprocal entry width
  localparam int MW = PW + RW + 1;   // scaled product width
  localparam int XW = MW + 1;        // subtract width before clamping

  typedef logic signed [SW-1:0] smp_t;
  typedef struct packed { smp_t re; smp_t im; } cpx_t;
  typedef struct packed { logic signed [EW-1:0] re; logic signed [EW-1:0] im; } err_t;
  typedef struct packed { logic signed [PW-1:0] re; logic signed [PW-1:0] im; } prd_t;

  typedef enum logic [2:0] {PH_IDLE, PH_RD, PH_MUL, PH_SUB, PH_WR} phase_t;

  // feedback minus desired output
  function automatic err_t cpx_diff(cpx_t fb, cpx_t want);
    err_t d;
    d.re = {fb.re[SW-1], fb.re} - {want.re[SW-1], want.re};
    d.im = {fb.im[SW-1], fb.im} - {want.im[SW-1], want.im};
    return d;
  endfunction

  // e times the conjugate of x
  function automatic prd_t mul_conj(err_t e, cpx_t x);
    prd_t p;
    logic signed [PW-1:0] rr, ii, ir, ri;
    rr = PW'(e.re) * PW'(x.re);
    ii = PW'(e.im) * PW'(x.im);
    ir = PW'(e.im) * PW'(x.re);
    ri = PW'(e.re) * PW'(x.im);
    p.re = rr + ii;
    p.im = ir - ri;
    return p;
  endfunction

  // per-bin 1/|x|^2 estimate at the bin centre, 2^rfrac scaled
  function automatic logic [RW-1:0] bin_recip(int k, int rfrac);
    longint num, den;
    num = longint'(1) <<< rfrac;
    den = longint'((2 * k + 1) * (2 * k + 1));
    return RW'(num / den);
  endfunction

  function automatic logic signed [MW-1:0] scale_prod(logic signed [PW-1:0] p,
                                                      logic [RW-1:0] r);
    logic signed [MW-1:0] rs;
    rs = MW'($signed({1'b0, r}));
    return MW'(p) * rs;
  endfunction

  // subtract shifted correction and clamp to the 16-bit signed range
  function automatic smp_t sat_step(smp_t g, logic signed [MW-1:0] m, logic [5:0] sh);
    logic signed [XW-1:0] d, v;
    smp_t res;
    d = XW'(m) >>> sh;
    v = XW'(g) - d;
    if (v[XW-1:SW-1] != {(XW-SW+1){v[XW-1]}})
      res = v[XW-1] ? smp_t'({1'b1, {(SW-1){1'b0}}}) : smp_t'({1'b0, {(SW-1){1'b1}}});
    else
      res = v[SW-1:0];
    return res;
  endfunction

endpackage

// File: rtl/lms_gain_table.sv
module lms_gain_table import lms_pkg::*; #(
  parameter int AW    = 6,
  parameter int GFRAC = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  cpx_t          wd,
  input  logic [AW-1:0] ra_a,
  output cpx_t          rd_a,
  input  logic [AW-1:0] ra_b,
  output cpx_t          rd_b
);
  localparam int   DEPTH    = 1 << AW;
  localparam smp_t UNITY_RE = smp_t'(1 << GFRAC);

  cpx_t mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem[i].re <= UNITY_RE;
        mem[i].im <= '0;
      end
      rd_a <= '0;
      rd_b <= '0;
    end else begin
      if (we) mem[wa] <= wd;
      rd_a <= mem[ra_a];
      rd_b <= mem[ra_b];
    end
  end

endmodule

// File: rtl/lms_recip_rom.sv
module lms_recip_rom import lms_pkg::*; #(
  parameter int AW    = 6,
  parameter int RFRAC = 16
) (
  input  logic [AW-1:0] idx,
  output logic [RW-1:0] recip
);
  localparam int DEPTH = 1 << AW;

  logic [RW-1:0] rom [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_bin
    assign rom[k] = bin_recip(k, RFRAC);
  end

  assign recip = rom[idx];

endmodule

// File: rtl/lms_drop_counter.sv
module lms_drop_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  output logic [CW-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (inc) count <= count + 1'b1;
  end

  a_r5_drop_inc: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> count == $past(count) + 1'b1);
  a_r5_drop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(count));

endmodule

// File: rtl/lms_update_ctrl.sv
module lms_update_ctrl import lms_pkg::*; #(
  parameter int AW  = 6,
  parameter int NSH = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adapt_en,
  input  logic [3:0]    mu_shift,
  input  logic          req_valid,
  input  logic [AW-1:0] req_idx,
  input  cpx_t          x_in,
  input  cpx_t          y_in,
  input  logic          host_we,
  input  logic [AW-1:0] host_idx,
  input  cpx_t          gain_rd,
  input  logic [RW-1:0] recip,
  output logic [AW-1:0] upd_idx,
  output logic          adapt_we,
  output cpx_t          adapt_gain,
  output logic          busy,
  output logic          drop_ev
);
  phase_t               ph;
  logic [AW-1:0]        idx_q;
  cpx_t                 x_q;
  err_t                 e_q;
  logic [3:0]           mu_q;
  logic                 cancel_q;
  prd_t                 prd_q;
  logic signed [MW-1:0] m_re_q, m_im_q;
  cpx_t                 new_q;

  logic       qualifies, accept, host_hit;
  logic [5:0] sh;

  assign qualifies  = req_valid && adapt_en && (req_idx != '0);
  assign busy       = (ph != PH_IDLE);
  assign accept     = qualifies && !busy;
  assign drop_ev    = qualifies && busy;
  assign host_hit   = busy && host_we && (host_idx == idx_q);
  assign adapt_we   = (ph == PH_WR) && !host_we && !cancel_q;
  assign upd_idx    = idx_q;
  assign adapt_gain = new_q;
  assign sh         = 6'(NSH) + {2'b00, mu_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= PH_IDLE;
      idx_q    <= '0;
      x_q      <= '0;
      e_q      <= '0;
      mu_q     <= '0;
      cancel_q <= 1'b0;
      prd_q    <= '0;
      m_re_q   <= '0;
      m_im_q   <= '0;
      new_q    <= '0;
    end else begin
      if (host_hit) cancel_q <= 1'b1;
      case (ph)
        PH_IDLE: if (accept) begin
          idx_q    <= req_idx;
          x_q      <= x_in;
          e_q      <= cpx_diff(y_in, x_in);
          mu_q     <= mu_shift;
          cancel_q <= 1'b0;
          ph       <= PH_RD;
        end
        PH_RD: begin
          prd_q <= mul_conj(e_q, x_q);
          ph    <= PH_MUL;
        end
        PH_MUL: begin
          m_re_q <= scale_prod(prd_q.re, recip);
          m_im_q <= scale_prod(prd_q.im, recip);
          ph     <= PH_SUB;
        end
        PH_SUB: begin
          new_q.re <= sat_step(gain_rd.re, m_re_q, sh);
          new_q.im <= sat_step(gain_rd.im, m_im_q, sh);
          ph       <= PH_WR;
        end
        PH_WR: begin
          if (cancel_q || !host_we) ph <= PH_IDLE;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  // R4: phases advance one per clock from acceptance
  a_r4_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ph == PH_RD);
  a_r4_rd_to_mul: assert property (@(posedge clk) disable iff (!rst_n)
    ph == PH_RD |=> ph == PH_MUL);
  a_r4_mul_to_sub: assert property (@(posedge clk) disable iff (!rst_n)
    ph == PH_MUL |=> ph == PH_SUB);
  a_r8_write_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_WR && host_we && !cancel_q && host_idx != idx_q) |=> ph == PH_WR);
  a_r9_cancel_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    host_hit |=> !adapt_we);
  a_r6_idx0_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_idx == '0 && !busy) |=> !busy);
  a_r7_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!adapt_en && !busy) |=> !busy);

endmodule

// File: rtl/lms_lut_updater.sv
module lms_lut_updater import lms_pkg::*; #(
  parameter int AW    = 6,
  parameter int GFRAC = 14,
  parameter int RFRAC = 16,
  parameter int CW    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adapt_en,
  input  logic [3:0]           mu_shift,
  input  logic                 req_valid,
  input  logic [AW-1:0]        req_idx,
  input  logic signed [SW-1:0] x_re,
  input  logic signed [SW-1:0] x_im,
  input  logic signed [SW-1:0] y_re,
  input  logic signed [SW-1:0] y_im,
  input  logic                 host_we,
  input  logic [AW-1:0]        host_idx,
  input  logic signed [SW-1:0] host_re,
  input  logic signed [SW-1:0] host_im,
  input  logic [AW-1:0]        lk_idx,
  output logic signed [SW-1:0] lk_re,
  output logic signed [SW-1:0] lk_im,
  output logic                 busy,
  output logic [CW-1:0]        drop_count
);
  localparam int BSH = SW - 1 - AW;                  // magnitude bin width, log2
  localparam int NSH = RFRAC + 2 * BSH - 2 - GFRAC;  // fixed normalisation shift

  cpx_t          x_c, y_c, host_c, rd_a, rd_b, adapt_gain, tbl_wd;
  logic [AW-1:0] upd_idx, tbl_wa;
  logic [RW-1:0] recip;
  logic          adapt_we, tbl_we, drop_ev;

  assign x_c.re    = x_re;
  assign x_c.im    = x_im;
  assign y_c.re    = y_re;
  assign y_c.im    = y_im;
  assign host_c.re = host_re;
  assign host_c.im = host_im;

  // shared write port, host first
  assign tbl_we = host_we | adapt_we;
  assign tbl_wa = host_we ? host_idx : upd_idx;
  assign tbl_wd = host_we ? host_c : adapt_gain;

  lms_gain_table #(.AW(AW), .GFRAC(GFRAC)) u_table (
    .clk(clk), .rst_n(rst_n), .we(tbl_we), .wa(tbl_wa), .wd(tbl_wd),
    .ra_a(upd_idx), .rd_a(rd_a), .ra_b(lk_idx), .rd_b(rd_b)
  );

  lms_recip_rom #(.AW(AW), .RFRAC(RFRAC)) u_recip (
    .idx(upd_idx), .recip(recip)
  );

  lms_update_ctrl #(.AW(AW), .NSH(NSH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .adapt_en(adapt_en), .mu_shift(mu_shift),
    .req_valid(req_valid), .req_idx(req_idx), .x_in(x_c), .y_in(y_c),
    .host_we(host_we), .host_idx(host_idx), .gain_rd(rd_a), .recip(recip),
    .upd_idx(upd_idx), .adapt_we(adapt_we), .adapt_gain(adapt_gain),
    .busy(busy), .drop_ev(drop_ev)
  );

  lms_drop_counter #(.CW(CW)) u_drops (
    .clk(clk), .rst_n(rst_n), .inc(drop_ev), .count(drop_count)
  );

  assign lk_re = rd_b.re;
  assign lk_im = rd_b.im;

  // R3: adaptation never writes the skipped near-zero bin
  a_r3_adapt_idx_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    adapt_we |-> upd_idx != '0);
  // R8: an adaptation write only lands on a cycle the host leaves free
  a_r8_port_free: assert property (@(posedge clk) disable iff (!rst_n)
    adapt_we |-> !host_we && busy);

endmodule

// File: tb/lms_lut_updater_bench.sv
module lms_lut_updater_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 64;
  localparam int RFRAC      = 16;
  localparam int NORM_SH    = 18;
  localparam int UNITY      = 16384;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              adapt_en = 1'b1;
  logic [3:0]        mu_shift = '0;
  logic              req_valid = 1'b0;
  logic [5:0]        req_idx = '0;
  logic signed [15:0] x_re = '0, x_im = '0, y_re = '0, y_im = '0;
  logic              host_we = 1'b0;
  logic [5:0]        host_idx = '0;
  logic signed [15:0] host_re = '0, host_im = '0;
  logic [5:0]        lk_idx = '0;
  logic signed [15:0] lk_re, lk_im;
  logic              busy;
  logic [7:0]        drop_count;

  int checks = 0;
  int fails  = 0;
  longint gm_re [DEPTH];
  longint gm_im [DEPTH];
  int exp_drops = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lms_lut_updater u_lms_lut_updater (
    .clk(clk), .rst_n(rst_n), .adapt_en(adapt_en), .mu_shift(mu_shift),
    .req_valid(req_valid), .req_idx(req_idx), .x_re(x_re), .x_im(x_im),
    .y_re(y_re), .y_im(y_im), .host_we(host_we), .host_idx(host_idx),
    .host_re(host_re), .host_im(host_im), .lk_idx(lk_idx), .lk_re(lk_re),
    .lk_im(lk_im), .busy(busy), .drop_count(drop_count)
  );

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic longint clamp16(longint v);
    if (v > 32767)  return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  // expected normalised LMS step on one component
  function automatic longint next_gain(longint g, longint p, int k, int mu);
    longint r, m;
    r = (longint'(1) <<< RFRAC) / longint'((2 * k + 1) * (2 * k + 1));
    m = (p * r) >>> (NORM_SH + mu);
    return clamp16(g - m);
  endfunction

  task automatic model_update(int k, longint xr, longint xi, longint yr, longint yi, int mu);
    longint er, ei, pr, pi;
    er = yr - xr;
    ei = yi - xi;
    pr = er * xr + ei * xi;
    pi = ei * xr - er * xi;
    gm_re[k] = next_gain(gm_re[k], pr, k, mu);
    gm_im[k] = next_gain(gm_im[k], pi, k, mu);
  endtask

  task automatic check_entry(string tag, int k);
    @(negedge clk);
    lk_idx = 6'(k);
    @(negedge clk);
    check({tag, " re"}, longint'(lk_re), gm_re[k]);
    check({tag, " im"}, longint'(lk_im), gm_im[k]);
  endtask

  // presents a request for one cycle; returns at the negedge after the accept edge
  task automatic issue(int k, int xr, int xi, int yr, int yi, int mu);
    @(negedge clk);
    req_valid = 1'b1;
    req_idx   = 6'(k);
    x_re = 16'(xr); x_im = 16'(xi); y_re = 16'(yr); y_im = 16'(yi);
    mu_shift  = 4'(mu);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic host_load(int k, int re, int im);
    @(negedge clk);
    host_we = 1'b1; host_idx = 6'(k); host_re = 16'(re); host_im = 16'(im);
    @(negedge clk);
    host_we = 1'b0;
    gm_re[k] = re;
    gm_im[k] = im;
  endtask

  task automatic t_reset;
    check("R1 busy after reset", longint'(busy), 0);
    check("R1 drop_count after reset", longint'(drop_count), 0);
    check_entry("R1 R12 entry 0", 0);
    check_entry("R1 R12 entry 33", 33);
    check_entry("R1 R12 entry 63", 63);
  endtask

  task automatic t_basic;
    issue(5, 3000, 1000, 3300, 900, 0);
    model_update(5, 3000, 1000, 3300, 900, 0);
    check("R4 busy after accept", longint'(busy), 1);
    repeat (3) @(negedge clk);
    check("R4 busy in fourth cycle", longint'(busy), 1);
    @(negedge clk);
    check("R4 busy cleared", longint'(busy), 0);
    check_entry("R2 entry 5", 5);
    check_entry("R3 entry 4", 4);
    check_entry("R3 entry 6", 6);
  endtask

  task automatic t_mu;
    issue(7, -5000, 2500, -4700, 2300, 3);
    mu_shift = 4'd0;  // R11: changed after acceptance
    model_update(7, -5000, 2500, -4700, 2300, 3);
    repeat (4) @(negedge clk);
    check_entry("R11 mu 3 entry 7", 7);
    issue(50, 20000, -15000, 18000, -14000, 15);
    model_update(50, 20000, -15000, 18000, -14000, 15);
    repeat (4) @(negedge clk);
    check_entry("R11 mu 15 entry 50", 50);
  endtask

  task automatic t_drop;
    issue(20, 10000, 4000, 11000, 3000, 1);
    model_update(20, 10000, 4000, 11000, 3000, 1);
    req_valid = 1'b1; req_idx = 6'd21;  // arrives while busy
    @(negedge clk);
    req_valid = 1'b0;
    exp_drops++;
    repeat (4) @(negedge clk);
    check("R5 drop_count", longint'(drop_count), exp_drops);
    check_entry("R5 entry 20 updated", 20);
    check_entry("R5 entry 21 untouched", 21);
  endtask

  task automatic t_idx0;
    issue(0, 6000, 6000, 1000, 1000, 0);
    check("R6 no busy for index 0", longint'(busy), 0);
    repeat (4) @(negedge clk);
    check("R6 index 0 not counted", longint'(drop_count), exp_drops);
    check_entry("R6 entry 0 untouched", 0);
  endtask

  task automatic t_enable;
    adapt_en = 1'b0;
    issue(30, 9000, -9000, 9500, -8000, 0);
    check("R7 no busy when disabled", longint'(busy), 0);
    repeat (4) @(negedge clk);
    check_entry("R7 entry 30 untouched", 30);
    check("R7 disabled not counted", longint'(drop_count), exp_drops);
    adapt_en = 1'b1;
    issue(31, 9000, -9000, 9500, -8000, 2);
    adapt_en = 1'b0;  // cleared mid-update
    model_update(31, 9000, -9000, 9500, -8000, 2);
    repeat (4) @(negedge clk);
    check_entry("R7 in-flight update completes", 31);
    adapt_en = 1'b1;
  endtask

  task automatic t_host_prio;
    issue(9, 12000, 3000, 12500, 2000, 0);
    model_update(9, 12000, 3000, 12500, 2000, 0);
    repeat (3) @(negedge clk);  // now in the write phase
    host_we = 1'b1; host_idx = 6'd40; host_re = 16'sd111; host_im = -16'sd222;
    @(negedge clk);
    check("R8 busy held by host write", longint'(busy), 1);
    @(negedge clk);
    host_we = 1'b0;
    gm_re[40] = 111;
    gm_im[40] = -222;
    check("R8 still pending", longint'(busy), 1);
    @(negedge clk);
    check("R8 released", longint'(busy), 0);
    check_entry("R8 host entry 40", 40);
    check_entry("R8 adapted entry 9", 9);
  endtask

  task automatic t_cancel;
    issue(11, 7000, 7000, 6000, 8000, 0);
    @(negedge clk);
    host_we = 1'b1; host_idx = 6'd11; host_re = 16'sd5000; host_im = -16'sd7000;
    @(negedge clk);
    host_we = 1'b0;
    gm_re[11] = 5000;
    gm_im[11] = -7000;
    repeat (3) @(negedge clk);
    check("R9 idle after cancel", longint'(busy), 0);
    check_entry("R9 host value kept", 11);
  endtask

  task automatic t_sat;
    host_load(12, 32000, -32000);
    issue(12, 8000, 0, 0, 8000, 0);
    model_update(12, 8000, 0, 0, 8000, 0);
    repeat (4) @(negedge clk);
    check_entry("R10 saturated entry 12", 12);
    check("R10 positive rail", gm_re[12], 32767);
    check("R10 negative rail", gm_im[12], -32768);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      gm_re[i] = UNITY;
      gm_im[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_mu();
    t_drop();
    t_idx0();
    t_enable();
    t_host_prio();
    t_cancel();
    t_sat();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule